// File: doc/BRIEF.md
# Quad Double-Buffered Converter Code Register Front End

This block is the digital side of a four-channel 12-bit digital-to-analog converter. A host drives a parallel data bus, a two-bit channel address and a set of active-low strobes. Each channel keeps two registers. The first stage is a staging register that the host writes one channel at a time. The second stage is an output register that drives the converter code for that channel. A group transfer copies all four staging registers into the output registers on the same clock edge, so the four analog outputs change together.

A width-select input lets an 8-bit host build a 12-bit word in two writes. The first write loads the eight upper bits. The second write routes the top nibble of the bus into the four low bits of the word. A clear strobe forces every output code to midscale, which is zero volts in offset binary. If the clear strobe is held while the transfer path is open, the outputs show midscale only for as long as clear stays low. When the strobes are tied active, the block passes bus data straight through to the addressed channel.

All strobes are level-sensitive enables that are sampled on each rising clock edge. An enable therefore takes effect only if it is held low across at least one edge.

Top module: `quad_dac_frontend`

## Requirements
- R1: The address selects the staging register that a write reaches: 0 selects channel 0, 1 selects channel 1, 2 selects channel 2 and 3 selects channel 3. The other three staging registers do not change.
- R2: A staging register changes only at a clock edge where `cs_n` and `wr1_n` are both 0. At any other edge all staging registers keep their values.
- R3: While `cs_n` and `wr1_n` stay low, the addressed staging register takes the bus value at every clock edge, so the last value sampled is the one kept.
- R4: With `full_word` = 1, a write stores all 12 bus bits unchanged.
- R5: With `full_word` = 0, a write stores bus bits 11..8 into staging bits 3..0 and leaves staging bits 11..4 unchanged.
- R6: At an edge where `wr2_n` and `xfer_n` are both 0 and `clr_n` is 1, all four output codes load their channel's staging value. The loaded value includes a staging write made at the same edge, and the new codes appear one clock later.
- R7: At an edge where `wr2_n` and `clr_n` are both 0, all four output codes become 12'h800. They stay at 12'h800 after `clr_n` returns high, unless a transfer follows.
- R8: With `wr2_n` and `xfer_n` held low, a low pulse on `clr_n` forces 12'h800 only while `clr_n` is low. One clock after `clr_n` returns high, the staging values show again.
- R9: Reset sets every output code and every staging register to 12'h800.
- R10: With `cs_n`, `wr1_n`, `wr2_n` and `xfer_n` all tied low, `clr_n` high and `full_word` = 1, the addressed channel's output code equals the bus value sampled one clock earlier.
- R11: When `clr_n` and `xfer_n` are both low with `wr2_n` low, the clear wins and all codes become 12'h800.
- R12: At an edge where `wr2_n` is 1, or where `xfer_n` and `clr_n` are both 1, the output codes do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples every enable |
| rst_n | input | 1 | Active-low power-on reset |
| bus_data | input | 12 | Parallel data bus |
| chan_addr | input | 2 | Channel select for staging writes |
| cs_n | input | 1 | Active-low chip select |
| wr1_n | input | 1 | Active-low staging write strobe |
| full_word | input | 1 | 1: write the whole word; 0: write the low nibble from bus bits 11..8 |
| wr2_n | input | 1 | Active-low enable for the output stage |
| xfer_n | input | 1 | Active-low group transfer |
| clr_n | input | 1 | Active-low midscale clear |
| out_codes | output | 48 | Offset-binary codes; channel n occupies bits 12n+11..12n |

## Verification
On every cycle, the assertions check the following:
- the staging registers hold when no write is enabled;
- only the addressed channel changes;
- byte-mode writes keep the upper eight bits and place the top nibble of the bus in the low bits;
- a clear produces midscale;
- a transfer copies the staging values;
- the outputs stay put when the output stage is closed.

Some behaviour only shows across a sequence, so the bench scenarios are needed for it:
- a word built from two byte-mode writes;
- a held clear releasing back to the staging contents;
- clear winning over transfer;
- pass-through with the address changing every cycle;
- the reset preset.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

    localparam int DEF_CHANNELS = 4;
    localparam int DEF_WIDTH    = 12;
    localparam int DEF_NIBBLE   = 4;

    typedef enum logic [1:0] {
        OUT_HOLD  = 2'd0,
        OUT_CLEAR = 2'd1,
        OUT_LOAD  = 2'd2
    } out_op_e;

    // Clear outranks transfer whenever the output stage is open.
    function automatic out_op_e decode_out_op(input logic wr2_n,
                                              input logic xfer_n,
                                              input logic clr_n);
        out_op_e op;
        op = OUT_HOLD;
        if (!wr2_n) begin
            if (!clr_n) begin
                op = OUT_CLEAR;
            end else if (!xfer_n) begin
                op = OUT_LOAD;
            end
        end
        return op;
    endfunction

endpackage

// File: rtl/dac_stage_bank.sv
module dac_stage_bank #(
    parameter int CHANNELS = dac_fe_pkg::DEF_CHANNELS,
    parameter int WIDTH    = dac_fe_pkg::DEF_WIDTH,
    parameter int NIBBLE   = dac_fe_pkg::DEF_NIBBLE,
    localparam int ABITS   = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cs_n,
    input  logic                             wr1_n,
    input  logic                             full_word,
    input  logic [ABITS-1:0]                 chan_addr,
    input  logic [WIDTH-1:0]                 bus_data,
    output logic [CHANNELS-1:0][WIDTH-1:0]   stage_d
);

    localparam logic [WIDTH-1:0] MID = WIDTH'(1) << (WIDTH - 1);

    typedef struct packed {
        logic [CHANNELS-1:0][WIDTH-1:0] regs;
    } stage_t;

    stage_t st_d, st_q;
    logic   write_en;

    assign write_en = !cs_n && !wr1_n;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < CHANNELS; i++) begin
            if (write_en && (chan_addr == ABITS'(i))) begin
                if (full_word) begin
                    st_d.regs[i] = bus_data;
                end else begin
                    st_d.regs[i][NIBBLE-1:0] = bus_data[WIDTH-1:WIDTH-NIBBLE];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.regs <= {CHANNELS{MID}};
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_d = st_d.regs;

    // R2: no write enable, no staging change
    a_r2_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cs_n && !wr1_n) |=> $stable(st_q));

    for (genvar g = 0; g < CHANNELS; g++) begin : g_chk
        // R1: a write aimed elsewhere leaves this channel alone
        a_r1_other_chan: assert property (@(posedge clk) disable iff (!rst_n)
            (!cs_n && !wr1_n && chan_addr != ABITS'(g)) |=> $stable(st_q.regs[g]));
        // R4: whole-word write
        a_r4_full_word: assert property (@(posedge clk) disable iff (!rst_n)
            (!cs_n && !wr1_n && full_word && chan_addr == ABITS'(g))
            |=> st_q.regs[g] == $past(bus_data));
        // R5: nibble write keeps the upper bits
        a_r5_nibble: assert property (@(posedge clk) disable iff (!rst_n)
            (!cs_n && !wr1_n && !full_word && chan_addr == ABITS'(g))
            |=> ($stable(st_q.regs[g][WIDTH-1:NIBBLE]) &&
                 st_q.regs[g][NIBBLE-1:0] == $past(bus_data[WIDTH-1:WIDTH-NIBBLE])));
    end

endmodule

// File: rtl/dac_output_bank.sv
module dac_output_bank #(
    parameter int CHANNELS = dac_fe_pkg::DEF_CHANNELS,
    parameter int WIDTH    = dac_fe_pkg::DEF_WIDTH
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr2_n,
    input  logic                             xfer_n,
    input  logic                             clr_n,
    input  logic [CHANNELS-1:0][WIDTH-1:0]   stage_d,
    output logic [CHANNELS-1:0][WIDTH-1:0]   code_q
);

    import dac_fe_pkg::*;

    localparam logic [WIDTH-1:0] MID = WIDTH'(1) << (WIDTH - 1);

    typedef struct packed {
        logic [CHANNELS-1:0][WIDTH-1:0] codes;
    } out_t;

    out_t    o_d, o_q;
    out_op_e op;

    always_comb begin
        op  = decode_out_op(wr2_n, xfer_n, clr_n);
        o_d = o_q;
        case (op)
            OUT_CLEAR: o_d.codes = {CHANNELS{MID}};
            OUT_LOAD:  o_d.codes = stage_d;
            default:   o_d = o_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q.codes <= {CHANNELS{MID}};
        end else begin
            o_q <= o_d;
        end
    end

    assign code_q = o_q.codes;

    // R7 and R11: an open clear gives midscale on every channel
    a_r7_clear_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr2_n && !clr_n) |=> code_q == {CHANNELS{MID}});

    // R6: transfer copies the staging values
    a_r6_group_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr2_n && !xfer_n && clr_n) |=> code_q == $past(stage_d));

    // R12: a closed output stage holds
    a_r12_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr2_n || (xfer_n && clr_n)) |=> $stable(code_q));

endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend #(
    parameter int CHANNELS = dac_fe_pkg::DEF_CHANNELS,
    parameter int WIDTH    = dac_fe_pkg::DEF_WIDTH,
    parameter int NIBBLE   = dac_fe_pkg::DEF_NIBBLE,
    localparam int ABITS   = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WIDTH-1:0]            bus_data,
    input  logic [ABITS-1:0]            chan_addr,
    input  logic                        cs_n,
    input  logic                        wr1_n,
    input  logic                        full_word,
    input  logic                        wr2_n,
    input  logic                        xfer_n,
    input  logic                        clr_n,
    output logic [CHANNELS*WIDTH-1:0]   out_codes
);

    logic [CHANNELS-1:0][WIDTH-1:0] stage_next;
    logic [CHANNELS-1:0][WIDTH-1:0] codes;

    dac_stage_bank #(
        .CHANNELS (CHANNELS),
        .WIDTH    (WIDTH),
        .NIBBLE   (NIBBLE)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wr1_n     (wr1_n),
        .full_word (full_word),
        .chan_addr (chan_addr),
        .bus_data  (bus_data),
        .stage_d   (stage_next)
    );

    dac_output_bank #(
        .CHANNELS (CHANNELS),
        .WIDTH    (WIDTH)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr2_n   (wr2_n),
        .xfer_n  (xfer_n),
        .clr_n   (clr_n),
        .stage_d (stage_next),
        .code_q  (codes)
    );

    assign out_codes = codes;

endmodule

// File: tb/tb_quad_dac_frontend.sv
`timescale 1ns/100ps
module tb_quad_dac_frontend;

    localparam logic [11:0] MID = 12'h800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_data = '0;
    logic [1:0]  chan_addr = '0;
    logic        cs_n = 1'b1, wr1_n = 1'b1, full_word = 1'b1;
    logic        wr2_n = 1'b1, xfer_n = 1'b1, clr_n = 1'b1;
    logic [47:0] out_codes;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [47:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    logic [11:0] m_in  [4];
    logic [11:0] m_out [4];

    quad_dac_frontend dut (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .chan_addr(chan_addr),
        .cs_n(cs_n), .wr1_n(wr1_n), .full_word(full_word), .wr2_n(wr2_n),
        .xfer_n(xfer_n), .clr_n(clr_n), .out_codes(out_codes)
    );

    always #2.5 clk = ~clk;

    function automatic logic [47:0] packed_model();
        return {m_out[3], m_out[2], m_out[1], m_out[0]};
    endfunction

    task automatic compare(input logic [47:0] act, input logic [47:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, expected result pushed to the scoreboard
    task automatic step(input logic cs, input logic w1, input logic w2,
                        input logic xf, input logic cl, input logic fw,
                        input logic [1:0] a, input logic [11:0] d, input string tag);
        @(negedge clk);
        cs_n = cs; wr1_n = w1; wr2_n = w2; xfer_n = xf; clr_n = cl;
        full_word = fw; chan_addr = a; bus_data = d;
        if (!cs && !w1) begin
            if (fw) m_in[a] = d;
            else    m_in[a][3:0] = d[11:8];
        end
        if (!w2) begin
            if (!cl) begin
                for (int i = 0; i < 4; i++) m_out[i] = MID;
            end else if (!xf) begin
                for (int i = 0; i < 4; i++) m_out[i] = m_in[i];
            end
        end
        sb.push_back('{exp: packed_model(), tag: tag});
    endtask

    task automatic wr(input logic [1:0] a, input logic [11:0] d, input logic fw, input string tag);
        step(0, 0, 1, 1, 1, fw, a, d, tag);
    endtask

    task automatic idle(input string tag);
        step(1, 1, 1, 1, 1, 1, 2'd0, 12'h000, tag);
    endtask

    task automatic xfer(input string tag);
        step(1, 1, 0, 0, 1, 1, 2'd0, 12'h000, tag);
    endtask

    // monitor: pops and compares one item per clock after outputs settle
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            compare(out_codes, it.exp, it.tag);
        end
    end

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_in[i]  = MID;
            m_out[i] = MID;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare(out_codes, {4{MID}}, "R9 reset preset");

        // R9: staging preset seen through a transfer right after reset
        xfer("R9 staging preset");

        // R1 R4 R2: whole-word writes do not reach outputs before transfer
        wr(2'd0, 12'h123, 1'b1, "R2 staged only ch0");
        wr(2'd1, 12'h456, 1'b1, "R2 staged only ch1");
        wr(2'd2, 12'h789, 1'b1, "R2 staged only ch2");
        wr(2'd3, 12'hABC, 1'b1, "R2 staged only ch3");
        // R2: chip select high blocks the write; wr1 high blocks it too
        step(1, 0, 1, 1, 1, 1, 2'd1, 12'hFFF, "R2 cs high ignored");
        step(0, 1, 1, 1, 1, 1, 2'd2, 12'hFFF, "R2 wr1 high ignored");
        xfer("R1 R4 group transfer");
        idle("R12 hold after transfer");

        // R5: two-write byte-mode build of 12'hA5C on channel 2
        wr(2'd2, 12'hA50, 1'b1, "R5 upper byte");
        wr(2'd2, 12'hC00, 1'b0, "R5 low nibble");
        xfer("R5 assembled word");
        // R5: a second nibble write keeps bits 11..4
        wr(2'd2, 12'h3FF, 1'b0, "R5 nibble only");
        xfer("R5 upper kept");

        // R3: strobes held low, last value wins
        wr(2'd3, 12'h111, 1'b1, "R3 follow 1");
        wr(2'd3, 12'h222, 1'b1, "R3 follow 2");
        wr(2'd3, 12'h333, 1'b1, "R3 follow 3");
        xfer("R3 last value kept");

        // R6: write and transfer at the same edge
        step(0, 0, 0, 0, 1, 1, 2'd0, 12'h0F0, "R6 same edge write");

        // R7: clear pulse with transfer idle, stays at midscale
        step(1, 1, 0, 1, 0, 1, 2'd0, 12'h000, "R7 clear");
        idle("R7 stays midscale");
        // R12: wr2 high with clear low changes nothing
        xfer("R7 restore");
        step(1, 1, 1, 1, 0, 1, 2'd0, 12'h000, "R12 clear without wr2");

        // R8: held clear over an open transfer path
        xfer("R8 open path");
        step(1, 1, 0, 0, 0, 1, 2'd0, 12'h000, "R8 clear held");
        step(1, 1, 0, 0, 0, 1, 2'd0, 12'h000, "R8 clear held 2");
        xfer("R8 release shows staging");

        // R11: clear and transfer together, clear wins
        wr(2'd1, 12'h5A5, 1'b1, "R11 stage");
        step(1, 1, 0, 0, 0, 1, 2'd0, 12'h000, "R11 clear beats transfer");

        // R10: fully transparent pass-through, address moving each cycle
        step(0, 0, 0, 0, 1, 1, 2'd0, 12'hFFF, "R10 pass ch0");
        step(0, 0, 0, 0, 1, 1, 2'd1, 12'h000, "R10 pass ch1");
        step(0, 0, 0, 0, 1, 1, 2'd2, 12'h801, "R10 pass ch2");
        step(0, 0, 0, 0, 1, 1, 2'd3, 12'h7FF, "R10 pass ch3");
        step(0, 0, 0, 0, 1, 1, 2'd3, 12'h001, "R10 pass ch3 again");
        idle("R12 final hold");

        repeat (3) @(negedge clk);
        done = 1'b1;
        report();
    end

endmodule